// File: doc/BRIEF.md
# Radio Transceiver Sleep/Wake Sequencer

This controller takes an attached RF transceiver from its active alert state down to a low-power sleep state and brings it back up. It does this with a fixed script of register transactions, which it sends through a single-outstanding command port toward an SPI master. On the way down, it stops automatic VCO calibration, passes the transceiver through the frequency-duplex state, and holds off for a flush interval that a counter times. It then parks the transceiver in wait and gates off its clocks. On the way up, it re-enables the clocks and reads the lock status register repeatedly until the PLL lock bit is set. It then forces alert and allows VCO calibration again.

Software or a power manager raises a one-cycle sleep or wake request. The controller reports whether it is busy. At the end of every sequence it pulses done. It keeps a sleeping flag, and it raises an error flag when the wait for PLL lock runs out of reads. Any request that is invalid for the present state, or that arrives while a sequence is running, is dropped and answered with a reject pulse.

Top module: `rf_pwr_seq`

## Requirements
- R1: A sleep request seen in the alert state produces exactly these writes, in this order: (0x230,0x55), (0x270,0x55), (0x014,0x00), (0x014,0x20), (0x014,0x00), (0x009,0x00). In each command, cmd_write=1 means a write and 0 means a read.
- R2: Consecutive transactions within a sequence are separated by exactly one cycle with cmd_valid low. The one exception is the write of 0x20 to 0x014: its response is followed by FLUSH_CYCLES+1 such cycles before the next command.
- R3: A wake request seen in the sleep state writes (0x009,0x17) and then reads 0x05E (cmd_write=0) until a response arrives with bit 7 set. After that it writes (0x014,0x05), (0x230,0x54) and (0x270,0x54), in that order.
- R4: If MAX_POLLS reads of 0x05E all return bit 7 clear, no further command is issued. err goes to 1 and sleeping stays 1. A new wake request is then accepted, it clears err, and it restarts the wake script.
- R5: Once cmd_valid is raised, it stays high with address, data and write flag unchanged until cmd_ready is seen. After that handshake, no new command appears until rsp_valid has returned.
- R6: A sleep request outside the alert state, a wake request outside the sleep or failed-wake states, or any request while busy is ignored. It adds no transaction and raises rejected for exactly one cycle, one cycle after the request. When both requests arrive together, the one valid for the state wins and the other is rejected.
- R7: done is high for one cycle, in the cycle after the response that ends a sequence (the last write, or the last failed lock read). busy is low in that cycle and high while any transaction or the flush wait is in progress.
- R8: sleeping becomes 1 together with done when a sleep sequence ends. It returns to 0 only together with done when a wake sequence succeeds.
- R9: After reset the controller is in the alert state with busy, done, err, rejected, sleeping and cmd_valid all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, taken equal to the converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter the low-power state |
| wake_req | input | 1 | Request to return to the alert state |
| cmd_valid | output | 1 | Command offered to the SPI master |
| cmd_ready | input | 1 | SPI master takes the command |
| cmd_addr | output | 10 | Register address of the command |
| cmd_wdata | output | 8 | Write data of the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| rsp_valid | input | 1 | Transaction completed |
| rsp_rdata | input | 8 | Read data returned with rsp_valid |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | Lock polling timed out |
| rejected | output | 1 | One-cycle pulse for an ignored request |
| sleeping | output | 1 | Transceiver is not in the alert state |

## Verification
Each result is due at a fixed offset from its cause. rejected is due one cycle after the request. done and the updated sleeping and err are due one cycle after the final response. A new command is due two cycles after the previous response, or FLUSH_CYCLES+2 cycles after the response to the force-transmit write. The bench samples at the falling edge and keeps a running cycle counter. For every transaction it records the cycle in which cmd_valid first appears and the cycle in which the response is driven. It then compares differences of those stamps with these offsets, rather than waiting loosely for an event. Stall and response latency of the modelled SPI slave are swept, together with the read on which lock appears, so the offsets are exercised under every handshake shape.

// File: rtl/rf_pwr_pkg.sv
package rf_pwr_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int STEP_W = 4;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } rf_op_t;

  typedef enum logic [2:0] {
    ST_ALERT,
    ST_SLEEP,
    ST_STUCK,
    ST_RUN,
    ST_FLUSH
  } seq_st_e;

  // Script positions that the sequencer branches on
  localparam logic [STEP_W-1:0] IX_SLEEP_FIRST = 4'd0;
  localparam logic [STEP_W-1:0] IX_FORCE_TX    = 4'd3;
  localparam logic [STEP_W-1:0] IX_SLEEP_LAST  = 4'd5;
  localparam logic [STEP_W-1:0] IX_WAKE_FIRST  = 4'd6;
  localparam logic [STEP_W-1:0] IX_POLL        = 4'd7;
  localparam logic [STEP_W-1:0] IX_WAKE_LAST   = 4'd10;

  function automatic rf_op_t mk_op(input logic wr, input logic [ADDR_W-1:0] a,
                                   input logic [DATA_W-1:0] d);
    rf_op_t o;
    o.wr   = wr;
    o.addr = a;
    o.data = d;
    return o;
  endfunction

  // Fixed transaction script: entries 0..5 go down, 6..10 come back up
  function automatic rf_op_t step_op(input logic [STEP_W-1:0] ix);
    case (ix)
      4'd0:    return mk_op(1'b1, 10'h230, 8'h55);
      4'd1:    return mk_op(1'b1, 10'h270, 8'h55);
      4'd2:    return mk_op(1'b1, 10'h014, 8'h00);
      4'd3:    return mk_op(1'b1, 10'h014, 8'h20);
      4'd4:    return mk_op(1'b1, 10'h014, 8'h00);
      4'd5:    return mk_op(1'b1, 10'h009, 8'h00);
      4'd6:    return mk_op(1'b1, 10'h009, 8'h17);
      4'd7:    return mk_op(1'b0, 10'h05E, 8'h00);
      4'd8:    return mk_op(1'b1, 10'h014, 8'h05);
      4'd9:    return mk_op(1'b1, 10'h230, 8'h54);
      default: return mk_op(1'b1, 10'h270, 8'h54);
    endcase
  endfunction

  function automatic logic lock_seen(input logic [DATA_W-1:0] d);
    return d[7];
  endfunction

endpackage

// File: rtl/rf_wait_timer.sv
module rf_wait_timer #(
  parameter int CYC = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  p_timer_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CW'(CYC - 1)) || (CYC == 1));

endmodule

// File: rtl/rf_cmd_port.sv
module rf_cmd_port import rf_pwr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rf_op_t            op_in,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_write,
  output logic              idle,
  output logic              fin,
  output logic [DATA_W-1:0] fin_data
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_st_e;

  port_st_e pst_q;
  rf_op_t   op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst_q <= P_IDLE;
      op_q  <= '0;
    end else begin
      case (pst_q)
        P_IDLE: if (start) begin
          op_q  <= op_in;
          pst_q <= P_REQ;
        end
        P_REQ:   if (cmd_ready) pst_q <= P_RSP;
        P_RSP:   if (rsp_valid) pst_q <= P_IDLE;
        default: pst_q <= P_IDLE;
      endcase
    end
  end

  assign cmd_valid = (pst_q == P_REQ);
  assign cmd_addr  = op_q.addr;
  assign cmd_wdata = op_q.data;
  assign cmd_write = op_q.wr;
  assign idle      = (pst_q == P_IDLE);
  assign fin       = (pst_q == P_RSP) && rsp_valid;
  assign fin_data  = rsp_rdata;

  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write)));

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !cmd_valid);

endmodule

// File: rtl/rf_pwr_seq.sv
module rf_pwr_seq import rf_pwr_pkg::*; #(
  parameter int FLUSH_CYCLES = 384,
  parameter int MAX_POLLS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_write,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rejected,
  output logic              sleeping
);
  localparam int PW  = $clog2(MAX_POLLS + 1);
  localparam int FRW = $clog2(FLUSH_CYCLES + 1);
  localparam logic [PW-1:0]  POLL_LAST  = PW'(MAX_POLLS - 1);
  localparam logic [FRW-1:0] FLUSH_LAST = FRW'(FLUSH_CYCLES - 1);

  seq_st_e           st_q;
  logic [STEP_W-1:0] ix_q;
  logic [PW-1:0]     poll_q;
  logic              sleeping_q, err_q, done_q, rej_q;

  // Named events for the assertions and the state update
  logic              accept_sleep, accept_wake, bad_req;
  logic              port_start, port_idle, port_fin;
  logic [DATA_W-1:0] port_data;
  logic              ev_flush_go, ev_lock, ev_poll_miss, ev_timeout;
  logic              ev_sleep_end, ev_wake_end, ev_finish;
  logic              tmr_zero;
  rf_op_t            cur_op;

  assign accept_sleep = sleep_req && (st_q == ST_ALERT);
  assign accept_wake  = wake_req && ((st_q == ST_SLEEP) || (st_q == ST_STUCK));
  assign bad_req      = (sleep_req && !accept_sleep) || (wake_req && !accept_wake);

  assign cur_op     = step_op(ix_q);
  assign port_start = (st_q == ST_RUN) && port_idle;

  assign ev_flush_go  = port_fin && (ix_q == IX_FORCE_TX);
  assign ev_lock      = port_fin && (ix_q == IX_POLL) && lock_seen(port_data);
  assign ev_poll_miss = port_fin && (ix_q == IX_POLL) && !lock_seen(port_data);
  assign ev_timeout   = ev_poll_miss && (poll_q == POLL_LAST);
  assign ev_sleep_end = port_fin && (ix_q == IX_SLEEP_LAST);
  assign ev_wake_end  = port_fin && (ix_q == IX_WAKE_LAST);
  assign ev_finish    = ev_sleep_end || ev_wake_end || ev_timeout;

  rf_cmd_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (port_start),
    .op_in     (cur_op),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_write (cmd_write),
    .idle      (port_idle),
    .fin       (port_fin),
    .fin_data  (port_data)
  );

  rf_wait_timer #(.CYC(FLUSH_CYCLES)) u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_flush_go),
    .zero  (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_ALERT;
      ix_q       <= IX_SLEEP_FIRST;
      poll_q     <= '0;
      sleeping_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_ALERT: if (accept_sleep) begin
          st_q <= ST_RUN;
          ix_q <= IX_SLEEP_FIRST;
        end
        ST_SLEEP, ST_STUCK: if (accept_wake) begin
          st_q   <= ST_RUN;
          ix_q   <= IX_WAKE_FIRST;
          poll_q <= '0;
          err_q  <= 1'b0;
        end
        ST_RUN: if (port_fin) begin
          if (ev_sleep_end) begin
            st_q       <= ST_SLEEP;
            sleeping_q <= 1'b1;
          end else if (ev_wake_end) begin
            st_q       <= ST_ALERT;
            sleeping_q <= 1'b0;
          end else if (ev_timeout) begin
            st_q  <= ST_STUCK;
            err_q <= 1'b1;
          end else if (ev_flush_go) begin
            st_q <= ST_FLUSH;
            ix_q <= ix_q + 1'b1;
          end else if (ev_poll_miss) begin
            poll_q <= poll_q + 1'b1;
          end else begin
            ix_q <= ix_q + 1'b1;
          end
        end
        ST_FLUSH: if (tmr_zero) st_q <= ST_RUN;
        default:  st_q <= ST_ALERT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      done_q <= ev_finish;
      rej_q  <= bad_req;
    end
  end

  assign busy     = (st_q == ST_RUN) || (st_q == ST_FLUSH);
  assign done     = done_q;
  assign err      = err_q;
  assign rejected = rej_q;
  assign sleeping = sleeping_q;

  // Independent length count of the flush wait, for checking only
  logic [FRW-1:0] flush_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || st_q != ST_FLUSH) flush_run_q <= '0;
    else                            flush_run_q <= flush_run_q + 1'b1;
  end

  p_flush_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH && tmr_zero) |-> (flush_run_q == FLUSH_LAST));

  p_flush_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH) |-> !cmd_valid);

  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= POLL_LAST);

  p_err_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sleeping && !busy));

  p_reject_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> $past(sleep_req || wake_req));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_lock_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> (busy && !cmd_valid));

  p_sleep_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sleeping)) |-> done);

endmodule

// File: tb/tb_rf_pwr_seq.sv
module tb_rf_pwr_seq;
  localparam int FLUSH = 12;
  localparam int MAXP  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0, wake_req = 1'b0;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [9:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic       cmd_write;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;
  logic       busy, done, err, rejected, sleeping;

  always #4 clk = ~clk;

  rf_pwr_seq #(.FLUSH_CYCLES(FLUSH), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_write(cmd_write), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .err(err),
    .rejected(rejected), .sleeping(sleeping));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Slave model state and transaction log
  int cyc = 0, stall = 0, lat = 0, lock_after = 0, reads = 0;
  int n_log = 0, done_cnt = 0, done_cyc = 0;
  int lg_we[32], lg_addr[32], lg_data[32], lg_start[32], lg_rsp[32];
  bit seen = 0, pend = 0;
  int stall_ctr = 0, lat_ctr = 0;
  int c_we, c_addr, c_data;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (rsp_valid) rsp_valid = 1'b0;
      if (cmd_ready) begin
        cmd_ready = 1'b0;
        chk(!cmd_valid, "R5 valid dropped after handshake", int'(cmd_valid), 0);
        pend = 1; lat_ctr = lat; seen = 0; stall_ctr = 0;
      end else if (cmd_valid) begin
        chk(!pend, "R5 command while response pending", int'(pend), 0);
        if (!seen) begin
          seen = 1; c_we = int'(cmd_write); c_addr = int'(cmd_addr); c_data = int'(cmd_wdata);
          if (n_log < 32) lg_start[n_log] = cyc;
        end
        if (stall_ctr >= stall) begin
          chk(c_addr == int'(cmd_addr) && c_data == int'(cmd_wdata) && c_we == int'(cmd_write),
              "R5 fields held until ready", int'(cmd_addr), c_addr);
          cmd_ready = 1'b1;
        end else stall_ctr++;
      end
      if (pend) begin
        if (lat_ctr == 0) begin
          pend = 0;
          rsp_rdata = 8'h00;
          if (c_we == 0 && c_addr == 'h05E) begin
            reads++;
            rsp_rdata = {(reads > lock_after), 7'h2A};
          end
          rsp_valid = 1'b1;
          if (n_log < 32) begin
            lg_we[n_log] = c_we; lg_addr[n_log] = c_addr; lg_data[n_log] = c_data;
            lg_rsp[n_log] = cyc;
          end
          n_log++;
        end else lat_ctr--;
      end
    end
  end

  // Expected script, restated from R1 and R3 as {we, addr, data}
  function automatic int sleep_word(input int k);
    case (k)
      0: return (1 << 18) | ('h230 << 8) | 'h55;
      1: return (1 << 18) | ('h270 << 8) | 'h55;
      2: return (1 << 18) | ('h014 << 8) | 'h00;
      3: return (1 << 18) | ('h014 << 8) | 'h20;
      4: return (1 << 18) | ('h014 << 8) | 'h00;
      default: return (1 << 18) | ('h009 << 8) | 'h00;
    endcase
  endfunction

  function automatic int wake_word(input int k, input int nreads);
    if (k == 0) return (1 << 18) | ('h009 << 8) | 'h17;
    if (k <= nreads) return ('h05E << 8);
    case (k - nreads)
      1: return (1 << 18) | ('h014 << 8) | 'h05;
      2: return (1 << 18) | ('h230 << 8) | 'h54;
      default: return (1 << 18) | ('h270 << 8) | 'h54;
    endcase
  endfunction

  task automatic wait_done(output bit ok);
    int t = 0;
    ok = 0;
    while (t < 4000 && !done) begin @(negedge clk); t++; end
    ok = done;
  endtask

  task automatic inject_busy_reject(input bit use_sleep);
    while (n_log < 2) @(negedge clk);
    if (use_sleep) sleep_req = 1'b1; else wake_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; wake_req = 1'b0;
    chk(rejected == 1'b1, "R6 request while busy rejected", int'(rejected), 1);
  endtask

  task automatic run_sleep(input bit both);
    bit ok;
    int d0;
    n_log = 0; d0 = done_cnt;
    @(negedge clk);
    sleep_req = 1'b1; wake_req = both;
    @(negedge clk);
    sleep_req = 1'b0; wake_req = 1'b0;
    chk(rejected == both, "R6 simultaneous wake rejected in alert", int'(rejected), int'(both));
    chk(busy == 1'b1, "R7 busy after accepted sleep", int'(busy), 1);
    inject_busy_reject(1'b0);
    wait_done(ok);
    chk(ok, "R7 sleep sequence finished", int'(ok), 1);
    chk(busy == 1'b0 && sleeping == 1'b1 && err == 1'b0, "R8 asleep after sleep done",
        {busy, sleeping, err}, 3'b010);
    @(negedge clk);
    chk(done == 1'b0 && done_cnt == d0 + 1, "R7 single done pulse", done_cnt - d0, 1);
    chk(n_log == 6, "R1 sleep transaction count (R6 ignored request)", n_log, 6);
    for (int k = 0; k < 6 && k < n_log; k++) begin
      int w;
      w = (lg_we[k] << 18) | (lg_addr[k] << 8) | lg_data[k];
      chk(w == sleep_word(k), "R1 sleep script entry", w, sleep_word(k));
      if (k > 0) chk(lg_start[k] - lg_rsp[k-1] - 1 == ((k == 4) ? FLUSH + 1 : 1),
                     "R2 idle cycles before command", lg_start[k] - lg_rsp[k-1] - 1,
                     (k == 4) ? FLUSH + 1 : 1);
    end
    if (n_log >= 6) chk(done_cyc == lg_rsp[5] + 1, "R7 done one cycle after last response",
                        done_cyc - lg_rsp[5], 1);
  endtask

  task automatic run_wake(input int n);
    bit ok, tmo;
    int nreads, total, d0;
    tmo = (n >= MAXP);
    nreads = tmo ? MAXP : n + 1;
    total = tmo ? 1 + MAXP : nreads + 4;
    n_log = 0; reads = 0; lock_after = n; d0 = done_cnt;
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk(rejected == 1'b0 && busy == 1'b1 && err == 1'b0, "R4 wake accepted and err cleared",
        {rejected, busy, err}, 3'b010);
    inject_busy_reject(1'b1);
    wait_done(ok);
    chk(ok, "R7 wake sequence finished", int'(ok), 1);
    chk(busy == 1'b0, "R7 idle at done", int'(busy), 0);
    if (tmo) chk(err == 1'b1 && sleeping == 1'b1, "R4 timeout flags", {err, sleeping}, 2'b11);
    else     chk(err == 1'b0 && sleeping == 1'b0, "R8 awake after wake done", {err, sleeping}, 2'b00);
    repeat (6) @(negedge clk);
    chk(n_log == total, "R3 wake transaction count (R4 no command after timeout)", n_log, total);
    chk(done_cnt == d0 + 1, "R7 one done per wake", done_cnt - d0, 1);
    for (int k = 0; k < total && k < n_log; k++) begin
      int w, e;
      w = (lg_we[k] << 18) | (lg_addr[k] << 8) | ((lg_we[k] != 0) ? lg_data[k] : 0);
      e = wake_word(k, nreads);
      chk(w == e, "R3 wake script entry", w, e);
      if (k > 0) chk(lg_start[k] - lg_rsp[k-1] - 1 == 1, "R2 idle cycles in wake",
                     lg_start[k] - lg_rsp[k-1] - 1, 1);
    end
    if (n_log >= total && total > 0)
      chk(done_cyc == lg_rsp[total-1] + 1, "R7 done after final wake response",
          done_cyc - lg_rsp[total-1], 1);
  endtask

  task automatic invalid_req(input bit use_sleep);
    int n0;
    bit s0, hit;
    n0 = n_log; s0 = sleeping; hit = 0;
    @(negedge clk);
    if (use_sleep) sleep_req = 1'b1; else wake_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; wake_req = 1'b0;
    chk(rejected == 1'b1, "R6 invalid request rejected", int'(rejected), 1);
    @(negedge clk);
    chk(rejected == 1'b0, "R6 reject lasts one cycle", int'(rejected), 0);
    repeat (5) begin @(negedge clk); if (cmd_valid || busy) hit = 1; end
    chk(!hit && n_log == n0 && sleeping == s0, "R6 invalid request has no effect",
        int'(hit), 0);
  endtask

  initial begin
    bit ok_r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, rejected, sleeping, cmd_valid} == 6'b0, "R9 reset outputs",
        {busy, done, err, rejected, sleeping, cmd_valid}, 0);
    invalid_req(1'b0);
    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 3; l += 2) begin
        for (int n = 0; n <= MAXP + 1; n++) begin
          stall = s; lat = l;
          run_sleep((n % 2) == 1);
          if (n == 0) invalid_req(1'b1);
          run_wake(n);
          if (n >= MAXP) begin
            invalid_req(1'b1);
            run_wake(0);
          end
        end
      end
    end
    ok_r = 1;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule